// File: doc/BRIEF.md
# Three-Phase PWM Timebase and Comparator

This block is the timing core of a three-phase motor waveform synthesizer. A prescaled counter runs either as an up-counting sawtooth, which gives edge-aligned pulses, or as an up/down triangle, which gives center-aligned pulses. Each of the three phase signals (U, V, W) is high while the counter is below that phase's active compare value. The raw, active-high phase signals go to a later stage that adds dead time and sets output polarity.

Software writes compare and period values through a small write port into staging registers. The staged values reach the active copies only at a period boundary, so a period in progress never sees a half-updated duty. An interrupt pulse marks period boundaries, decimated by 1, 2, 4 or 8. It can instead mark every half period.

Top module: `pwm3_timebase`

## Requirements
- R1: After reset, out_u, out_v, out_w and irq are low. The staged and active compare values are 0 and the period value is all ones, so enabling without any write keeps every phase low.
- R2: clk_sel selects the number of clock cycles per counter step: 00 = 2, 01 = 4, 10 = 8, 11 = 16.
- R3: With tri_mode = 0 the counter steps 0, 1, … P and then returns to 0, where P is the active period value. One period is P+1 steps.
- R4: With tri_mode = 1 the counter steps from 0 up to P and back down to 0. Both 0 and P last one step, so one period is 2·P steps.
- R5: A phase is high while the counter is below its active compare value C. C = 0 keeps the phase low for the whole period, and C ≥ P keeps it high for the whole period.
- R6: The write port selects a target with wr_sel: 00 = U compare, 01 = V compare, 10 = W compare, 11 = period. With indep_duty = 0 all three phases use the U compare value. With indep_duty = 1 each phase uses its own value.
- R7: A write made while enabled takes effect at the next period boundary: the wrap to 0 in sawtooth mode, or the step leaving 0 in triangle mode. The period in progress is unchanged. While disabled, the active values follow the staged values.
- R8: irq is a one-cycle pulse issued once every 1, 2, 4 or 8 periods, as irq_rate is 00, 01, 10 or 11.
- R9: With irq_half = 1 and irq_rate = 00, irq pulses twice per period. In triangle mode the pulses come at the peak and the valley. In sawtooth mode they come at the wrap and at the step leaving count floor(P/2). With irq_rate ≠ 00, irq_half has no effect.
- R10: With en = 0 all phases are low, irq is low, and the counter, prescaler and interrupt decimator are held at zero. Decimation therefore restarts when en goes from 0 to 1.
- R11: clk_sel and tri_mode are captured only while en = 0. Changes to them while en = 1 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Waveform enable |
| clk_sel | input | 2 | Counter step divider select |
| tri_mode | input | 1 | 0 = sawtooth, 1 = triangle counting |
| indep_duty | input | 1 | 0 = all phases use U compare, 1 = independent |
| irq_rate | input | 2 | Interrupt decimation select |
| irq_half | input | 1 | Half-period interrupt request |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register write target |
| wr_data | input | CNT_W | Register write data |
| out_u | output | 1 | U phase duty, active high |
| out_v | output | 1 | V phase duty, active high |
| out_w | output | 1 | W phase duty, active high |
| irq | output | 1 | Period interrupt pulse |

## Verification
The hardest case to reach from the ports is a compare write that lands inside a running period. The write must be timed against the counter, which the bench cannot read. The stimulus therefore waits for an interrupt, writes a new U compare a few cycles later, and expects the old duty for the rest of that period and the new duty for the following one. Each interrupt interval is measured in clock cycles together with the high-cycle count of every phase. One measurement then covers the divider, the counting shape, the compare rule and the decimation at once.

// File: rtl/pwm3_timebase.sv
module pwm3_timebase #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [1:0]       clk_sel,
  input  logic             tri_mode,
  input  logic             indep_duty,
  input  logic [1:0]       irq_rate,
  input  logic             irq_half,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [CNT_W-1:0] wr_data,
  output logic             out_u,
  output logic             out_v,
  output logic             out_w,
  output logic             irq
);
  localparam int PRE_W = 4;
  localparam int NREG  = 4;
  localparam int PER   = 3;

  logic [1:0]       sel_q;
  logic             tri_q;
  logic [PRE_W-1:0] pre_q, pre_last;
  logic [CNT_W-1:0] cnt_q;
  logic             up_q;
  logic [2:0]       dec_q, rate_mask;
  logic             irq_q;
  logic [CNT_W-1:0] front_q [NREG];
  logic [CNT_W-1:0] act_q   [NREG];
  logic [CNT_W-1:0] per, cmp [3];
  logic [2:0]       on;
  logic tick, wrap, valley, peak, period_ev, half_ev, load, half_mode;

  assign pre_last  = PRE_W'((5'd2 << sel_q) - 5'd1);
  assign tick      = en && (pre_q == pre_last);
  assign per       = act_q[PER];
  assign wrap      = !tri_q && (cnt_q >= per);
  assign valley    = tri_q && !up_q && (cnt_q == '0);
  assign peak      = tri_q && up_q && (cnt_q >= per);
  assign period_ev = tick && (wrap || valley);
  assign half_ev   = tick && (tri_q ? peak : (!wrap && cnt_q == (per >> 1)));
  assign load      = !en || period_ev;
  assign half_mode = irq_half && (irq_rate == 2'b00);
  assign rate_mask = 3'((4'd1 << irq_rate) - 4'd1);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sel_q <= '0;
      tri_q <= 1'b0;
    end else if (!en) begin
      sel_q <= clk_sel;
      tri_q <= tri_mode;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pre_q <= '0;
      cnt_q <= '0;
      up_q  <= 1'b1;
    end else if (!en) begin
      pre_q <= '0;
      cnt_q <= '0;
      up_q  <= 1'b1;
    end else begin
      pre_q <= tick ? '0 : pre_q + 1'b1;
      if (tick) begin
        if (!tri_q) begin
          cnt_q <= wrap ? '0 : cnt_q + 1'b1;
        end else if (up_q) begin
          if (cnt_q >= per) begin
            up_q  <= 1'b0;
            cnt_q <= (cnt_q == '0) ? '0 : cnt_q - 1'b1;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end else begin
          if (cnt_q == '0) begin
            up_q  <= 1'b1;
            cnt_q <= (per == '0) ? '0 : CNT_W'(1);
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      dec_q <= '0;
      irq_q <= 1'b0;
    end else if (!en) begin
      dec_q <= '0;
      irq_q <= 1'b0;
    end else begin
      irq_q <= half_mode ? (period_ev || half_ev)
                         : (period_ev && dec_q >= rate_mask);
      if (period_ev) dec_q <= (dec_q >= rate_mask) ? '0 : dec_q + 1'b1;
    end

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        front_q[i] <= (i == PER) ? '1 : '0;
        act_q[i]   <= (i == PER) ? '1 : '0;
      end else begin
        if (wr_en && wr_sel == 2'(i)) front_q[i] <= wr_data;
        if (load) act_q[i] <= front_q[i];
      end
  end

  assign cmp[0] = act_q[0];
  assign cmp[1] = indep_duty ? act_q[1] : act_q[0];
  assign cmp[2] = indep_duty ? act_q[2] : act_q[0];

  for (genvar p = 0; p < 3; p++) begin : g_phase
    assign on[p] = en && ((cmp[p] >= per) || (cnt_q < cmp[p]));
  end

  assign out_u = on[0];
  assign out_v = on[1];
  assign out_w = on[2];
  assign irq   = irq_q;
endmodule

// File: rtl/pwm3_timebase_chk.sv
module pwm3_timebase_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic             indep_duty,
  input logic             out_u,
  input logic             out_v,
  input logic             out_w,
  input logic             irq,
  input logic [CNT_W-1:0] cnt_q,
  input logic [1:0]       sel_q,
  input logic             tri_q
);
  AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq); // R8

  AST_OFF_PHASES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !out_u && !out_v && !out_w); // R10

  AST_OFF_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !irq); // R10

  AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    en && $past(en) && !$stable(cnt_q) |->
      (cnt_q == $past(cnt_q) + CNT_W'(1)) ||
      (cnt_q == $past(cnt_q) - CNT_W'(1)) || (cnt_q == '0)); // R3

  AST_MODE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    en && $past(en) |-> $stable(sel_q) && $stable(tri_q)); // R11

  AST_SHARED_DUTY: assert property (@(posedge clk) disable iff (!rst_n)
    en && !indep_duty |-> (out_v == out_u) && (out_w == out_u)); // R6
endmodule

bind pwm3_timebase pwm3_timebase_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .indep_duty(indep_duty),
  .out_u(out_u), .out_v(out_v), .out_w(out_w), .irq(irq),
  .cnt_q(cnt_q), .sel_q(sel_q), .tri_q(tri_q)
);

// File: tb/pwm3_timebase_tb.sv
module pwm3_timebase_tb;
  localparam int CNT_W = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic en = 0, tri_mode = 0, indep_duty = 0, irq_half = 0, wr_en = 0;
  logic [1:0] clk_sel = 0, irq_rate = 0, wr_sel = 0;
  logic [CNT_W-1:0] wr_data = 0;
  logic out_u, out_v, out_w, irq;

  pwm3_timebase #(.CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .clk_sel(clk_sel), .tri_mode(tri_mode),
    .indep_duty(indep_duty), .irq_rate(irq_rate), .irq_half(irq_half),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .out_u(out_u), .out_v(out_v), .out_w(out_w), .irq(irq));

  typedef struct {int cyc; int hu; int hv; int hw; string tag;} exp_t;
  exp_t q[$];
  exp_t e;
  int n_chk = 0, n_bad = 0;
  bit armed = 0;
  int acc_c = 0, acc_u = 0, acc_v = 0, acc_w = 0;

  task automatic check(string tag, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin : monitor
    if (!rst_n || !en) begin
      armed = 0;
    end else begin
      if (irq) begin
        if (armed && q.size() > 0) begin
          e = q.pop_front();
          check(e.tag, "irq interval", acc_c, e.cyc);
          if (e.hu >= 0) check(e.tag, "U high cycles", acc_u, e.hu);
          if (e.hv >= 0) check(e.tag, "V high cycles", acc_v, e.hv);
          if (e.hw >= 0) check(e.tag, "W high cycles", acc_w, e.hw);
        end
        armed = 1;
        acc_c = 0; acc_u = 0; acc_v = 0; acc_w = 0;
      end
      acc_c++;
      acc_u += int'(out_u);
      acc_v += int'(out_v);
      acc_w += int'(out_w);
    end
  end

  function automatic int hi_steps(int tm, int p, int c);
    if (tm == 0) return (c >= p) ? p + 1 : c;
    return (c >= p) ? 2 * p : ((c == 0) ? 0 : 2 * c - 1);
  endfunction

  task automatic wr(int s, int d);
    @(negedge clk);
    wr_en = 1; wr_sel = 2'(s); wr_data = CNT_W'(d);
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic push(string tag, int n, int sel, int tm, int ind, int rate,
                      int half, int p, int cu, int cv, int cw);
    int d = 2 << sel;
    int m = 1 << rate;
    exp_t x;
    x.tag = tag;
    if (half != 0 && rate == 0) begin
      x.cyc = (tm != 0 ? p : (p + 1) / 2) * d;
      x.hu = -1; x.hv = -1; x.hw = -1;
    end else begin
      x.cyc = (tm != 0 ? 2 * p : p + 1) * d * m;
      x.hu = hi_steps(tm, p, cu) * d * m;
      x.hv = hi_steps(tm, p, ind != 0 ? cv : cu) * d * m;
      x.hw = hi_steps(tm, p, ind != 0 ? cw : cu) * d * m;
    end
    for (int i = 0; i < n; i++) q.push_back(x);
  endtask

  task automatic drain();
    while (q.size() != 0) @(negedge clk);
  endtask

  task automatic run_case(string tag, int n, int sel, int tm, int ind, int rate,
                          int half, int p, int cu, int cv, int cw, bit disturb);
    @(negedge clk); en = 0;
    wr(3, p); wr(0, cu); wr(1, cv); wr(2, cw);
    clk_sel = 2'(sel); tri_mode = tm[0]; indep_duty = ind[0];
    irq_rate = 2'(rate); irq_half = half[0];
    repeat (2) @(negedge clk);
    en = 1;
    if (disturb) begin
      @(negedge clk);
      clk_sel = ~clk_sel; tri_mode = ~tri_mode;
    end
    push(tag, n, sel, tm, ind, rate, half, p, cu, cv, cw);
    drain();
    en = 0;
    @(negedge clk);
    check("R10", "phases low after disable", int'({out_u, out_v, out_w}), 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : driver
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1", "phases after reset", int'({out_u, out_v, out_w}), 0);
    check("R1", "irq after reset", int'(irq), 0);
    en = 1; indep_duty = 1;
    repeat (40) @(negedge clk);
    check("R1", "phases with default compare", int'({out_u, out_v, out_w}), 0);
    en = 0;

    // R2 R3 R5: divide by 2, sawtooth, 0% / mid / 100%
    run_case("R3", 3, 0, 0, 1, 0, 0, 9, 0, 4, 12, 0);
    // R2 R4 R5: divide by 4, triangle
    run_case("R4", 3, 1, 1, 1, 0, 0, 6, 3, 6, 1, 0);
    // R2 R6: divide by 8, shared U duty
    run_case("R6", 2, 2, 0, 0, 0, 0, 5, 2, 5, 0, 0);
    // R8: decimation by 4 and by 8 (divide by 16)
    run_case("R8", 2, 0, 0, 1, 2, 0, 4, 3, 0, 4, 0);
    run_case("R2", 2, 3, 1, 0, 3, 0, 3, 2, 0, 0, 0);
    // R9: half-period interrupts in both shapes, ignored with rate 01
    run_case("R9", 4, 0, 1, 1, 0, 1, 7, 2, 3, 4, 0);
    run_case("R9", 4, 1, 0, 1, 0, 1, 9, 2, 3, 4, 0);
    run_case("R9", 2, 0, 0, 1, 1, 1, 9, 2, 3, 4, 0);
    // R11: mode inputs toggled while running
    run_case("R11", 3, 0, 0, 1, 0, 0, 9, 3, 5, 7, 1);

    // R7: compare write during a running period
    @(negedge clk); en = 0;
    wr(3, 9); wr(0, 2); wr(1, 0); wr(2, 0);
    clk_sel = 0; tri_mode = 0; indep_duty = 1; irq_rate = 0; irq_half = 0;
    repeat (2) @(negedge clk);
    en = 1;
    push("R7", 2, 0, 0, 1, 0, 0, 9, 2, 0, 0);
    drain();
    push("R7", 1, 0, 0, 1, 0, 0, 9, 2, 0, 0);
    push("R7", 1, 0, 0, 1, 0, 0, 9, 7, 0, 0);
    wr(0, 7);
    drain();
    en = 0;
    @(negedge clk);
    check("R10", "phases low after disable", int'({out_u, out_v, out_w}), 0);
    check("R10", "irq low after disable", int'(irq), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule